// File: doc/BRIEF.md
# Multi-Slot Key Store

This block keeps a small set of secret keys in an internal word RAM and hands a chosen key to a cipher engine when asked. Each slot holds one key and has a valid flag. Software works through five word-wide registers. It sets the key length, picks the slot that the next incoming key lands in, clears or inspects the per-slot valid flags, requests delivery of a slot to the engine, and reads or clears two sticky error flags.

Key material arrives from an upstream loader as a stream of 32-bit words, least significant word first. Once the last word of a key has been stored, the slot becomes valid and its write-select bit drops. A delivery request copies the slot word by word into an assembly register while a busy flag is shown. The full key is then presented to the engine together with a one-cycle load strobe. Changing the key length in any way discards every stored key. A delivery request for an empty slot, or a key word that has no enabled slot to land in, raises an error flag.

Top module: `keyslot_store`

## Requirements
- R1: After reset, the size register (offset 0) reads 1, the write-select (offset 1), valid (offset 2), read-select (offset 3) and error (offset 4) registers read 0, and the load strobe is low.
- R2: Writing the valid register (offset 2) clears the valid flag of each slot whose bit is 1 in the written value and leaves the other slots unchanged.
- R3: Any write to the size register (offset 0) clears every valid flag, even when the written value equals the stored one.
- R4: When several bits of the write-select register (offset 1, bit n selects slot n) are set, incoming words go to the lowest-numbered selected slot only.
- R5: Key words fill the target slot least significant word first. The first word clears that slot's valid flag. The last word sets it and clears the slot's write-select bit.
- R6: Writing a slot index to the read-select register (offset 3, index in the low bits, busy in bit 31) while that slot is valid sets busy. The key is presented with a one-cycle load strobe in the N-th cycle after the write, where N is the words per key, and busy falls in that same cycle.
- R7: A read request for a slot whose valid flag is clear sets error bit 1 (offset 4), does not set busy and produces no load strobe.
- R8: A key word that arrives while no write-select bit is set is dropped and sets error bit 0 (offset 4).
- R9: With size bit 0 written to 0 (half length), a key is two words long, and on delivery the upper half of the key output is zero. Size bit 0 equal to 1 selects the full length of four words.
- R10: A read-select write made while busy is ignored: the delivery in progress completes with its own slot, and the index readback does not change.
- R11: Error flags stay set until a 1 is written to their bit in the error register (offset 4).
- R12: A write to the write-select or size register restarts a partly received key, so the next word is taken as word 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset for reads and writes |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| kin_valid | input | 1 | Key word present on kin_word |
| kin_word | input | WORD_BITS | Incoming key word |
| eng_key | output | KEY_BITS | Delivered key, stable between load strobes |
| eng_load | output | 1 | One-cycle strobe marking a new key on eng_key |

## Verification
The bench uses the default parameters: eight slots, 128-bit keys and 32-bit words. With these values the full-length fill and fetch take four words each, and half length takes two. This covers both fetch latencies, both ends of the slot range (slots 0 and 7), and a lowest-bit choice between adjacent slots. The error paths, the restart of a partly received key, and requests made while busy are all checked in the same configuration.

// File: rtl/kvs_pkg.sv
package kvs_pkg;
   localparam int REG_AW = 3;
   localparam int REG_W  = 32;

   localparam logic [REG_AW-1:0] KVS_REG_SIZE  = 3'd0;
   localparam logic [REG_AW-1:0] KVS_REG_WRSEL = 3'd1;
   localparam logic [REG_AW-1:0] KVS_REG_VALID = 3'd2;
   localparam logic [REG_AW-1:0] KVS_REG_RDSEL = 3'd3;
   localparam logic [REG_AW-1:0] KVS_REG_ERR   = 3'd4;

   localparam int ERR_WR_BIT  = 0;
   localparam int ERR_RD_BIT  = 1;
   localparam int BUSY_BIT    = 31;
endpackage

// File: rtl/kvs_word_ram.sv
module kvs_word_ram #(
   parameter int DEPTH = 32,
   parameter int WIDTH = 32,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem_q[waddr] <= wdata;
   end

   assign rdata = mem_q[raddr];
endmodule

// File: rtl/kvs_fill_ctrl.sv
module kvs_fill_ctrl #(
   parameter int NUM_SLOTS     = 8,
   parameter int WORDS_PER_KEY = 4,
   localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
   localparam int CNT_W  = (WORDS_PER_KEY > 1) ? $clog2(WORDS_PER_KEY) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_SLOTS-1:0]    sel_mask,
   input  logic                    restart,
   input  logic                    half,
   input  logic                    kin_valid,
   output logic                    ram_we,
   output logic [SLOT_W+CNT_W-1:0] ram_waddr,
   output logic [SLOT_W-1:0]       tgt_slot,
   output logic                    first_word,
   output logic                    commit,
   output logic                    drop_err
);
   localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(WORDS_PER_KEY - 1);
   localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(WORDS_PER_KEY / 2 - 1);

   logic              any_sel;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  last_idx;

   // lowest-numbered selected slot wins
   always_comb begin
      any_sel  = 1'b0;
      tgt_slot = '0;
      for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
         if (sel_mask[i]) begin
            any_sel  = 1'b1;
            tgt_slot = SLOT_W'(i);
         end
      end
   end

   assign last_idx   = half ? HALF_LAST : FULL_LAST;
   assign ram_we     = kin_valid & any_sel;
   assign ram_waddr  = {tgt_slot, cnt_q};
   assign first_word = ram_we & (cnt_q == '0);
   assign commit     = ram_we & (cnt_q == last_idx);
   assign drop_err   = kin_valid & ~any_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (restart)  cnt_q <= '0;
      else if (ram_we)   cnt_q <= (cnt_q == last_idx) ? '0 : cnt_q + 1'b1;
   end
endmodule

// File: rtl/kvs_fetch_ctrl.sv
module kvs_fetch_ctrl #(
   parameter int NUM_SLOTS     = 8,
   parameter int WORDS_PER_KEY = 4,
   parameter int WORD_BITS     = 32,
   localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
   localparam int CNT_W    = (WORDS_PER_KEY > 1) ? $clog2(WORDS_PER_KEY) : 1,
   localparam int KEY_BITS = WORDS_PER_KEY * WORD_BITS
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [SLOT_W-1:0]       slot,
   input  logic                    half,
   input  logic [WORD_BITS-1:0]    ram_rdata,
   output logic [SLOT_W+CNT_W-1:0] ram_raddr,
   output logic                    busy,
   output logic                    load,
   output logic [KEY_BITS-1:0]     key
);
   localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(WORDS_PER_KEY - 1);
   localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(WORDS_PER_KEY / 2 - 1);

   logic                busy_q, load_q, half_q;
   logic [SLOT_W-1:0]   slot_q;
   logic [CNT_W-1:0]    cnt_q;
   logic [KEY_BITS-1:0] acc_q, acc_nxt, key_q;
   logic [CNT_W-1:0]    last_idx;

   assign last_idx  = half_q ? HALF_LAST : FULL_LAST;
   assign ram_raddr = {slot_q, cnt_q};

   always_comb begin
      acc_nxt = acc_q;
      acc_nxt[int'(cnt_q) * WORD_BITS +: WORD_BITS] = ram_rdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         load_q <= 1'b0;
         half_q <= 1'b0;
         slot_q <= '0;
         cnt_q  <= '0;
         acc_q  <= '0;
         key_q  <= '0;
      end else begin
         load_q <= 1'b0;
         if (start && !busy_q) begin
            busy_q <= 1'b1;
            slot_q <= slot;
            half_q <= half;
            cnt_q  <= '0;
            acc_q  <= '0;
         end else if (busy_q) begin
            acc_q <= acc_nxt;
            if (cnt_q == last_idx) begin
               busy_q <= 1'b0;
               load_q <= 1'b1;
               key_q  <= acc_nxt;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign busy = busy_q;
   assign load = load_q;
   assign key  = key_q;
endmodule

// File: rtl/keyslot_store.sv
module keyslot_store
   import kvs_pkg::*;
#(
   parameter int NUM_SLOTS = 8,
   parameter int KEY_BITS  = 128,
   parameter int WORD_BITS = 32,
   localparam int WORDS_PER_KEY = KEY_BITS / WORD_BITS,
   localparam int SLOT_W        = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
   localparam int CNT_W         = (WORDS_PER_KEY > 1) ? $clog2(WORDS_PER_KEY) : 1,
   localparam int RAM_DEPTH     = NUM_SLOTS * WORDS_PER_KEY
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [REG_AW-1:0]    cfg_addr,
   input  logic [REG_W-1:0]     cfg_wdata,
   output logic [REG_W-1:0]     cfg_rdata,
   input  logic                 kin_valid,
   input  logic [WORD_BITS-1:0] kin_word,
   output logic [KEY_BITS-1:0]  eng_key,
   output logic                 eng_load
);
   // elaboration-time parameter checks
   if (KEY_BITS % WORD_BITS != 0) begin : g_chk_div
      $error("KEY_BITS must be a multiple of WORD_BITS");
   end
   if (WORDS_PER_KEY < 4 || (WORDS_PER_KEY & (WORDS_PER_KEY - 1)) != 0) begin : g_chk_words
      $error("words per key must be a power of two, at least 4");
   end
   if (NUM_SLOTS < 2 || NUM_SLOTS > REG_W || (NUM_SLOTS & (NUM_SLOTS - 1)) != 0) begin : g_chk_slots
      $error("NUM_SLOTS must be a power of two between 2 and the register width");
   end

   logic                   size_full_q;
   logic [NUM_SLOTS-1:0]   wrsel_q, wrsel_nxt;
   logic [NUM_SLOTS-1:0]   valid_q, valid_nxt;
   logic [SLOT_W-1:0]      rd_slot_q;
   logic                   err_wr_q, err_rd_q;

   logic wr_size, wr_wrsel, wr_valid, wr_rdsel, wr_err;
   assign wr_size  = cfg_we && (cfg_addr == KVS_REG_SIZE);
   assign wr_wrsel = cfg_we && (cfg_addr == KVS_REG_WRSEL);
   assign wr_valid = cfg_we && (cfg_addr == KVS_REG_VALID);
   assign wr_rdsel = cfg_we && (cfg_addr == KVS_REG_RDSEL);
   assign wr_err   = cfg_we && (cfg_addr == KVS_REG_ERR);

   // fill path
   logic                    f_we, f_first, f_commit, f_drop;
   logic [SLOT_W+CNT_W-1:0] f_waddr;
   logic [SLOT_W-1:0]       f_slot;

   kvs_fill_ctrl #(
      .NUM_SLOTS    (NUM_SLOTS),
      .WORDS_PER_KEY(WORDS_PER_KEY)
   ) fill_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_mask  (wrsel_q),
      .restart   (wr_wrsel | wr_size),
      .half      (~size_full_q),
      .kin_valid (kin_valid),
      .ram_we    (f_we),
      .ram_waddr (f_waddr),
      .tgt_slot  (f_slot),
      .first_word(f_first),
      .commit    (f_commit),
      .drop_err  (f_drop)
   );

   // fetch path
   logic                    r_busy, r_start, r_bad;
   logic [SLOT_W-1:0]       r_req;
   logic [SLOT_W+CNT_W-1:0] r_raddr;
   logic [WORD_BITS-1:0]    r_rdata;

   assign r_req   = cfg_wdata[SLOT_W-1:0];
   assign r_start = wr_rdsel && !r_busy && valid_q[r_req];
   assign r_bad   = wr_rdsel && !r_busy && !valid_q[r_req];

   kvs_fetch_ctrl #(
      .NUM_SLOTS    (NUM_SLOTS),
      .WORDS_PER_KEY(WORDS_PER_KEY),
      .WORD_BITS    (WORD_BITS)
   ) fetch_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (r_start),
      .slot     (r_req),
      .half     (~size_full_q),
      .ram_rdata(r_rdata),
      .ram_raddr(r_raddr),
      .busy     (r_busy),
      .load     (eng_load),
      .key      (eng_key)
   );

   kvs_word_ram #(
      .DEPTH(RAM_DEPTH),
      .WIDTH(WORD_BITS)
   ) ram_i (
      .clk  (clk),
      .we   (f_we),
      .waddr(f_waddr),
      .wdata(kin_word),
      .raddr(r_raddr),
      .rdata(r_rdata)
   );

   // per-slot flag updates; priority: size write, software clear, fill events
   always_comb begin
      valid_nxt = valid_q;
      wrsel_nxt = wrsel_q;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         if (f_commit && f_slot == SLOT_W'(i)) begin
            valid_nxt[i] = 1'b1;
            wrsel_nxt[i] = 1'b0;
         end else if (f_first && f_slot == SLOT_W'(i)) begin
            valid_nxt[i] = 1'b0;
         end
         if (wr_valid && cfg_wdata[i]) valid_nxt[i] = 1'b0;
      end
      if (wr_size)  valid_nxt = '0;
      if (wr_wrsel) wrsel_nxt = cfg_wdata[NUM_SLOTS-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         size_full_q <= 1'b1;
         wrsel_q     <= '0;
         valid_q     <= '0;
         rd_slot_q   <= '0;
         err_wr_q    <= 1'b0;
         err_rd_q    <= 1'b0;
      end else begin
         valid_q <= valid_nxt;
         wrsel_q <= wrsel_nxt;
         if (wr_size) size_full_q <= cfg_wdata[0];
         if (wr_rdsel && !r_busy) rd_slot_q <= r_req;
         if (f_drop) err_wr_q <= 1'b1;
         else if (wr_err && cfg_wdata[ERR_WR_BIT]) err_wr_q <= 1'b0;
         if (r_bad) err_rd_q <= 1'b1;
         else if (wr_err && cfg_wdata[ERR_RD_BIT]) err_rd_q <= 1'b0;
      end
   end

   always_comb begin
      cfg_rdata = '0;
      case (cfg_addr)
         KVS_REG_SIZE:  cfg_rdata[0] = size_full_q;
         KVS_REG_WRSEL: cfg_rdata[NUM_SLOTS-1:0] = wrsel_q;
         KVS_REG_VALID: cfg_rdata[NUM_SLOTS-1:0] = valid_q;
         KVS_REG_RDSEL: begin
            cfg_rdata[SLOT_W-1:0] = rd_slot_q;
            cfg_rdata[BUSY_BIT]   = r_busy;
         end
         KVS_REG_ERR: begin
            cfg_rdata[ERR_WR_BIT] = err_wr_q;
            cfg_rdata[ERR_RD_BIT] = err_rd_q;
         end
         default: cfg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/kvs_store_chk.sv
module kvs_store_chk #(
   parameter int NUM_SLOTS = 8,
   localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cfg_we,
   input logic [2:0]           cfg_addr,
   input logic [31:0]          cfg_wdata,
   input logic                 kin_valid,
   input logic                 eng_load,
   input logic                 busy,
   input logic [NUM_SLOTS-1:0] valid,
   input logic [NUM_SLOTS-1:0] wrsel,
   input logic                 err_wr,
   input logic                 err_rd
);
   AST_SIZE_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == 3'd0) |=> (valid == '0)); // R3

   AST_VALID_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == 3'd2) |=> ((valid & $past(cfg_wdata[NUM_SLOTS-1:0])) == '0)); // R2

   AST_LOAD_AT_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
      eng_load |-> $fell(busy)); // R6

   AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      eng_load |=> !eng_load); // R6

   AST_EMPTY_READ_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == 3'd3 && !busy && !valid[cfg_wdata[SLOT_W-1:0]]) |=> (err_rd && !busy)); // R7

   AST_DROP_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (kin_valid && wrsel == '0) |=> err_wr); // R8

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err_rd && !(cfg_we && cfg_addr == 3'd4 && cfg_wdata[1])) |=> err_rd); // R11
endmodule

bind keyslot_store kvs_store_chk #(.NUM_SLOTS(NUM_SLOTS)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_we   (cfg_we),
   .cfg_addr (cfg_addr),
   .cfg_wdata(cfg_wdata),
   .kin_valid(kin_valid),
   .eng_load (eng_load),
   .busy     (r_busy),
   .valid    (valid_q),
   .wrsel    (wrsel_q),
   .err_wr   (err_wr_q),
   .err_rd   (err_rd_q)
);

// File: tb/keyslot_store_tb_top.sv
module keyslot_store_tb_top;
   localparam int NS  = 8;
   localparam int KB  = 128;
   localparam int WB  = 32;
   localparam int WPK = KB / WB;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [2:0]    cfg_addr = 3'd0;
   logic [31:0]   cfg_wdata = '0;
   logic [31:0]   cfg_rdata;
   logic          kin_valid = 1'b0;
   logic [WB-1:0] kin_word = '0;
   logic [KB-1:0] eng_key;
   logic          eng_load;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   bit cur_half = 1'b0;

   always #2 clk = ~clk;

   keyslot_store #(.NUM_SLOTS(NS), .KEY_BITS(KB), .WORD_BITS(WB)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .kin_valid(kin_valid),
      .kin_word(kin_word), .eng_key(eng_key), .eng_load(eng_load)
   );

   // slot[39:36] half[35:32] base[31:0]
   localparam logic [39:0] VEC [6] = '{
      40'h0_0_1111_0000,
      40'h7_0_A5A5_5A5A,
      40'h3_1_0BAD_F00D,
      40'h5_1_7E57_0001,
      40'h1_0_C0DE_2222,
      40'h6_0_FFFF_FFF0
   };

   task automatic check(input string req, input logic [KB-1:0] act, input logic [KB-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cfg_read(input logic [2:0] a, output logic [31:0] d);
      cfg_addr = a;
      #1;
      d = cfg_rdata;
   endtask

   task automatic feed(input logic [WB-1:0] w);
      kin_valid = 1'b1; kin_word = w;
      @(negedge clk);
      kin_valid = 1'b0;
   endtask

   function automatic logic [WB-1:0] word_of(input logic [31:0] base, input int i);
      return base + 32'h1020_3041 * i;
   endfunction

   function automatic logic [KB-1:0] key_of(input logic [31:0] base, input bit half);
      logic [KB-1:0] k = '0;
      for (int i = 0; i < (half ? WPK/2 : WPK); i++) k[i*WB +: WB] = word_of(base, i);
      return k;
   endfunction

   task automatic fill(input int slot, input logic [31:0] base, input bit half);
      cfg_write(3'd1, 32'(1) << slot);
      for (int i = 0; i < (half ? WPK/2 : WPK); i++) feed(word_of(base, i));
   endtask

   task automatic wait_load(output int n);
      n = 99;
      for (int c = 1; c <= 12; c++) begin
         @(negedge clk);
         if (eng_load) begin n = c; break; end
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      cfg_read(3'd0, d); check("R1 size", KB'(d), KB'(1));
      cfg_read(3'd1, d); check("R1 wrsel", KB'(d), '0);
      cfg_read(3'd2, d); check("R1 valid", KB'(d), '0);
      cfg_read(3'd3, d); check("R1 rdsel", KB'(d), '0);
      cfg_read(3'd4, d); check("R1 err", KB'(d), '0);
      check("R1 load", KB'(eng_load), '0);

      // table of fill and fetch cases (R5 R6 R9)
      foreach (VEC[v]) begin
         automatic int      slot = int'(VEC[v][39:36]);
         automatic bit      half = VEC[v][32];
         automatic logic [31:0] base = VEC[v][31:0];
         if (half != cur_half) begin
            cfg_write(3'd0, {31'd0, ~half});
            cur_half = half;
         end
         fill(slot, base, half);
         cfg_read(3'd2, d); check("R5 valid set", KB'(d[slot]), KB'(1));
         cfg_read(3'd1, d); check("R5 wrsel cleared", KB'(d), '0);
         cfg_write(3'd3, 32'(slot));
         cfg_read(3'd3, d); check("R6 busy", KB'(d[31]), KB'(1));
         wait_load(n);
         check(half ? "R9 latency" : "R6 latency", KB'(n), KB'(half ? WPK/2 : WPK));
         check(half ? "R9 key upper zero" : "R6 key", eng_key, key_of(base, half));
         cfg_read(3'd3, d); check("R6 busy low", KB'(d[31]), '0);
      end

      // R3: size write with same value wipes all
      cfg_write(3'd0, 32'd1); cur_half = 1'b0;
      fill(0, 32'h0101_0101, 1'b0);
      fill(2, 32'h0202_0202, 1'b0);
      cfg_read(3'd2, d); check("R3 prefill", KB'(d[7:0]), KB'(8'h05));
      cfg_write(3'd0, 32'd1);
      cfg_read(3'd2, d); check("R3 wiped", KB'(d), '0);

      // R2: write-1 clears selected slots only
      fill(0, 32'h0101_0101, 1'b0);
      fill(2, 32'h0202_0202, 1'b0);
      fill(4, 32'h0404_0404, 1'b0);
      cfg_write(3'd2, 32'h0000_0011);
      cfg_read(3'd2, d); check("R2 w1c", KB'(d[7:0]), KB'(8'h04));

      // R4: lowest selected slot wins
      cfg_write(3'd1, 32'h0000_0060);
      for (int i = 0; i < WPK; i++) feed(word_of(32'h5555_0000, i));
      cfg_read(3'd2, d); check("R4 slot5 only", KB'(d[7:0]), KB'(8'h24));
      cfg_read(3'd1, d); check("R4 wrsel left", KB'(d), KB'(32'h40));
      cfg_write(3'd1, 32'd0);

      // R5 first word clears; R12 restart
      cfg_write(3'd1, 32'h4);
      feed(32'hDEAD_0000);
      cfg_read(3'd2, d); check("R5 first word clears", KB'(d[2]), '0);
      feed(32'hDEAD_0001);
      cfg_write(3'd1, 32'h4);
      for (int i = 0; i < WPK; i++) feed(word_of(32'h1234_5678, i));
      cfg_read(3'd2, d); check("R12 valid after restart", KB'(d[2]), KB'(1));
      cfg_write(3'd3, 32'd2);
      wait_load(n);
      check("R12 key after restart", eng_key, key_of(32'h1234_5678, 1'b0));

      // R8: word with no selection
      feed(32'hBAD0_BAD0);
      cfg_read(3'd4, d); check("R8 err wr", KB'(d[1:0]), KB'(2'b01));
      cfg_read(3'd2, d); check("R8 valid untouched", KB'(d[7:0]), KB'(8'h24));

      // R7: empty slot read
      cfg_write(3'd3, 32'd7);
      cfg_read(3'd3, d); check("R7 no busy", KB'(d[31]), '0);
      cfg_read(3'd4, d); check("R7 err rd", KB'(d[1:0]), KB'(2'b11));
      wait_load(n); check("R7 no load", KB'(n), KB'(99));

      // R11: sticky then write-1 clear
      cfg_write(3'd4, 32'd0);
      cfg_read(3'd4, d); check("R11 sticky", KB'(d[1:0]), KB'(2'b11));
      cfg_write(3'd4, 32'd1);
      cfg_read(3'd4, d); check("R11 clear wr", KB'(d[1:0]), KB'(2'b10));
      cfg_write(3'd4, 32'd2);
      cfg_read(3'd4, d); check("R11 clear rd", KB'(d[1:0]), '0);

      // R10: request while busy ignored
      cfg_write(3'd3, 32'd5);
      cfg_write(3'd3, 32'd2);
      cfg_read(3'd3, d); check("R10 index kept", KB'(d[2:0]), KB'(5));
      wait_load(n);
      check("R10 latency", KB'(n), KB'(WPK - 1));
      check("R10 key of first", eng_key, key_of(32'h5555_0000, 1'b0));
      cfg_read(3'd4, d); check("R10 no error", KB'(d[1:0]), '0);

      finish_run();
   end
endmodule